// File: doc/BRIEF.md
# Capture/Reload Timer with Serial Baud Output

This block is a 16-bit up-counter controlled through a byte-wide special-function-register port. It can count core clock cycles or falling edges on an external count pin. A second pin, the trigger, can be used in two ways. It can copy the live count into a capture register. Or it can force the count to reload from that same register, which then serves as the reload value.

An overflow always happens on the step out of all-ones. In reload mode the reload value is loaded in that same cycle. In capture mode the count wraps to zero.

The block has a baud mode for a neighbouring serial port. Two select bits steer the receive and transmit bit clocks to this timer's overflow pulses. While either select bit is set, three things change:
- The counter always reloads on overflow, whatever the capture-mode bit says.
- The overflow flag is never raised.
- Trigger events are ignored.

The interrupt request is the OR of the overflow flag and the trigger flag. Software clears each flag by writing 0 to it.

Top module: `cap_reload_timer`

## Requirements
- R1: After a synchronous reset, the control byte, the count and the capture/reload register all read 0. The outputs irq, rx_clk_sel, tx_clk_sel and ovf_pulse are all 0.
- R2: The control byte is at address 0xC8. Bit 2 (run) enables counting. Bit 1 chooses the source: 0 counts every core clock, 1 counts external events. The count is read and written at 0xCC (low byte) and 0xCD (high byte). While run is 0, the count holds its value.
- R3: With bit 1 set, the count steps once per falling edge of cnt_pin, seen after a two-flop synchroniser. Levels and rising edges do not change the count.
- R4: With bit 0 (capture mode) clear, a step from 0xFFFF loads the capture/reload register (0xCA low byte, 0xCB high byte) into the count in that same cycle. The step also sets bit 7 (overflow flag).
- R5: With bits 0 and 3 (trigger enable) both set, a synchronised falling edge on trig_pin copies the count into the capture/reload register and sets bit 6 (trigger flag). The count keeps running undisturbed. In capture mode an overflow wraps the count to 0.
- R6: With bit 0 clear and bit 3 set, a synchronised falling edge on trig_pin loads the count from the capture/reload register and sets bit 6.
- R7: With bit 3 clear, trig_pin falling edges change neither the capture/reload register nor bit 6.
- R8: Baud mode is active while bit 5 or bit 4 is set. In baud mode an overflow always reloads, even with bit 0 set. Bit 7 stays 0, and trig_pin edges neither capture, reload nor set bit 6.
- R9: rx_clk_sel follows bit 5 and tx_clk_sel follows bit 4. ovf_pulse is high for one cycle, the cycle after each overflow, in every mode.
- R10: irq is 1 while bit 7 or bit 6 is 1. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged, so software cannot set a flag.
- R11: A capture and an overflow in the same cycle both take effect. The register receives 0xFFFF, the count becomes 0, and both flags are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wr | input | 1 | Write strobe, one byte per cycle |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for sfr_addr (combinational) |
| cnt_pin | input | 1 | External count input, asynchronous |
| trig_pin | input | 1 | External capture/reload trigger, asynchronous |
| irq | output | 1 | Interrupt request |
| rx_clk_sel | output | 1 | Receive clock uses this timer's overflow |
| tx_clk_sel | output | 1 | Transmit clock uses this timer's overflow |
| ovf_pulse | output | 1 | One-cycle pulse per overflow |

## Verification
A trigger capture and a counter overflow can fall into the same clock cycle. The two then compete over the count and the capture/reload register. The bench provokes this by presetting the count to 0xFFFD and starting the timer. It drops trig_pin exactly two cycles before the count reaches 0xFFFF, which matches the synchroniser and edge-detector latency. The result is judged at the ports: the register must read 0xFFFF, the count must have wrapped and kept running from 0, both flags must be set, and one more overflow pulse must be counted.

// File: rtl/crt_pkg.sv
package crt_pkg;

    localparam int BYTE_W = 8;

    // Control byte, most significant bit first.
    typedef struct packed {
        logic ovf_flag;   // bit 7
        logic ext_flag;   // bit 6
        logic rx_sel;     // bit 5
        logic tx_sel;     // bit 4
        logic trig_en;    // bit 3
        logic run;        // bit 2
        logic ext_cnt;    // bit 1
        logic cap_mode;   // bit 0
    } ctrl_t;

    // What the count register does in a given cycle.
    typedef enum logic [2:0] {
        CA_HOLD   = 3'd0,
        CA_STEP   = 3'd1,
        CA_RELOAD = 3'd2,
        CA_WRAP   = 3'd3,
        CA_SW     = 3'd4
    } cnt_act_e;

    function automatic logic is_baud(ctrl_t c);
        return c.rx_sel | c.tx_sel;
    endfunction

    function automatic logic is_reload(ctrl_t c);
        return is_baud(c) | ~c.cap_mode;
    endfunction

endpackage

// File: rtl/crt_pin_fall.sv
module crt_pin_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], pin};
    end

    assign fall = chain[STAGES] & ~chain[STAGES-1];

    // R3: a detected falling edge never lasts two cycles
    assert_fall_single_R3: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/crt_ctrl_reg.sv
module crt_ctrl_reg
    import crt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                set_ovf,
    input  logic                set_ext,
    output ctrl_t               ctrl
);
    ctrl_t ctrl_q, ctrl_d, wr_view;

    assign wr_view = ctrl_t'(wdata);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d = wr_view;
            // flags: writing 0 clears, writing 1 keeps
            ctrl_d.ovf_flag = ctrl_q.ovf_flag & wr_view.ovf_flag;
            ctrl_d.ext_flag = ctrl_q.ext_flag & wr_view.ext_flag;
        end
        if (set_ovf) ctrl_d.ovf_flag = 1'b1;
        if (set_ext) ctrl_d.ext_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    // R10: flags are sticky until software writes 0
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ovf_flag && !(wr && !wr_view.ovf_flag)) |=> ctrl_q.ovf_flag);
    assert_ext_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ext_flag && !(wr && !wr_view.ext_flag)) |=> ctrl_q.ext_flag);
    // R10: software alone cannot raise a flag
    assert_no_sw_set_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.ovf_flag && !set_ovf) |=> !ctrl_q.ovf_flag);
    // R8: baud mode never raises the overflow flag
    assert_baud_no_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.ovf_flag && (ctrl_q.rx_sel || ctrl_q.tx_sel)) |=> !ctrl_q.ovf_flag);

endmodule

// File: rtl/crt_counter.sv
module crt_counter
    import crt_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NB   = CNT_W / BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  ctrl_t               ctrl,
    input  logic                cnt_fall,
    input  logic                trig_fall,
    input  logic [NB-1:0]       cnt_wr_b,
    input  logic [NB-1:0]       rld_wr_b,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [CNT_W-1:0]    count_o,
    output logic [CNT_W-1:0]    rld_o,
    output logic                ovf_o,
    output logic                set_ovf_o,
    output logic                set_ext_o
);
    logic [CNT_W-1:0] count_q, count_d, rld_q, rld_d;
    logic [CNT_W-1:0] cnt_merge, rld_merge;
    logic             tick, baud, reload_m, trig_evt, cap_evt, ovf, sw_cnt;
    cnt_act_e         act;

    assign baud     = is_baud(ctrl);
    assign reload_m = is_reload(ctrl);
    assign tick     = ctrl.run & (ctrl.ext_cnt ? cnt_fall : 1'b1);
    assign ovf      = tick & (count_q == '1);
    assign trig_evt = trig_fall & ctrl.trig_en & ~baud;
    assign cap_evt  = trig_evt & ~reload_m;
    assign sw_cnt   = |cnt_wr_b;

    always_comb begin
        cnt_merge = count_q;
        rld_merge = rld_q;
        for (int i = 0; i < NB; i++) begin
            if (cnt_wr_b[i]) cnt_merge[i*BYTE_W +: BYTE_W] = wdata;
            if (rld_wr_b[i]) rld_merge[i*BYTE_W +: BYTE_W] = wdata;
        end
    end

    // priority: software write, trigger reload, overflow, step
    always_comb begin
        if (sw_cnt)                    act = CA_SW;
        else if (trig_evt && reload_m) act = CA_RELOAD;
        else if (ovf)                  act = reload_m ? CA_RELOAD : CA_WRAP;
        else if (tick)                 act = CA_STEP;
        else                           act = CA_HOLD;
    end

    always_comb begin
        unique case (act)
            CA_SW:     count_d = cnt_merge;
            CA_RELOAD: count_d = rld_q;
            CA_WRAP:   count_d = '0;
            CA_STEP:   count_d = count_q + CNT_W'(1);
            default:   count_d = count_q;
        endcase
    end

    // a hardware capture wins over a software write of the same register
    assign rld_d = cap_evt ? count_q : rld_merge;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            rld_q   <= '0;
        end else begin
            count_q <= count_d;
            rld_q   <= rld_d;
        end
    end

    assign count_o   = count_q;
    assign rld_o     = rld_q;
    assign ovf_o     = ovf;
    assign set_ovf_o = ovf & ~baud;
    assign set_ext_o = trig_evt;

    // R2: free-running step on the core clock
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !ctrl.ext_cnt && count_q != '1 && !trig_fall && cnt_wr_b == '0)
        |=> count_q == $past(count_q) + CNT_W'(1));
    // R2: a stopped counter holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !trig_fall && cnt_wr_b == '0) |=> $stable(count_q));
    // R4: overflow in reload mode loads the reload value
    assert_ovf_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !ctrl.ext_cnt && count_q == '1 && reload_m && cnt_wr_b == '0)
        |=> count_q == $past(rld_q));
    // R5: overflow in capture mode wraps to zero
    assert_cap_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !ctrl.ext_cnt && count_q == '1 && !reload_m && cnt_wr_b == '0)
        |=> count_q == '0);
    // R5: a trigger in capture mode stores the count
    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (trig_fall && ctrl.trig_en && ctrl.cap_mode && !baud) |=> rld_q == $past(count_q));
    // R6: a trigger in reload mode loads the count
    assert_trig_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (trig_fall && ctrl.trig_en && !ctrl.cap_mode && !baud && cnt_wr_b == '0)
        |=> count_q == $past(rld_q));
    // R7: triggers are ignored without the enable
    assert_trig_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.trig_en && rld_wr_b == '0) |=> $stable(rld_q));
    // R8: no capture in baud mode
    assert_baud_no_capture_R8: assert property (@(posedge clk) disable iff (rst)
        (baud && rld_wr_b == '0) |=> $stable(rld_q));
    // R11: capture and wrap in the same cycle
    assert_cap_and_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        (trig_fall && ctrl.trig_en && ctrl.cap_mode && !baud && ctrl.run &&
         !ctrl.ext_cnt && count_q == '1 && cnt_wr_b == '0)
        |=> (count_q == '0 && rld_q == '1));

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import crt_pkg::*;
#(
    parameter int          CNT_W       = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CTRL_ADDR   = 8'hC8,
    parameter logic [7:0]  CNT_ADDR    = 8'hCC,
    parameter logic [7:0]  RLD_ADDR    = 8'hCA
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  sfr_addr,
    input  logic        sfr_wr,
    input  logic [7:0]  sfr_wdata,
    output logic [7:0]  sfr_rdata,
    input  logic        cnt_pin,
    input  logic        trig_pin,
    output logic        irq,
    output logic        rx_clk_sel,
    output logic        tx_clk_sel,
    output logic        ovf_pulse
);
    localparam int NB = CNT_W / BYTE_W;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] count, rld;
    logic [NB-1:0]    cnt_wr_b, rld_wr_b;
    logic             cnt_fall, trig_fall, ovf, set_ovf, set_ext, ctrl_wr;

    assign ctrl_wr = sfr_wr && (sfr_addr == CTRL_ADDR);

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign cnt_wr_b[i] = sfr_wr && (sfr_addr == CNT_ADDR + 8'(i));
        assign rld_wr_b[i] = sfr_wr && (sfr_addr == RLD_ADDR + 8'(i));
    end

    crt_pin_fall #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst(rst), .pin(cnt_pin), .fall(cnt_fall));

    crt_pin_fall #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst(rst), .pin(trig_pin), .fall(trig_fall));

    crt_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(sfr_wdata),
        .set_ovf(set_ovf), .set_ext(set_ext), .ctrl(ctrl));

    crt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .ctrl(ctrl), .cnt_fall(cnt_fall),
        .trig_fall(trig_fall), .cnt_wr_b(cnt_wr_b), .rld_wr_b(rld_wr_b),
        .wdata(sfr_wdata), .count_o(count), .rld_o(rld), .ovf_o(ovf),
        .set_ovf_o(set_ovf), .set_ext_o(set_ext));

    always_comb begin
        sfr_rdata = '0;
        if (sfr_addr == CTRL_ADDR) sfr_rdata = ctrl;
        for (int i = 0; i < NB; i++) begin
            if (sfr_addr == CNT_ADDR + 8'(i)) sfr_rdata = count[i*BYTE_W +: BYTE_W];
            if (sfr_addr == RLD_ADDR + 8'(i)) sfr_rdata = rld[i*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ovf_pulse <= 1'b0;
        else     ovf_pulse <= ovf;
    end

    assign irq        = ctrl.ovf_flag | ctrl.ext_flag;
    assign rx_clk_sel = ctrl.rx_sel;
    assign tx_clk_sel = ctrl.tx_sel;

    // R9: each overflow yields a pulse one cycle later
    assert_pulse_follows_R9: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf_pulse);

endmodule

// File: tb/cap_reload_timer_bench.sv
module cap_reload_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = '0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = '0;
    logic [7:0] sfr_rdata;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       irq, rx_clk_sel, tx_clk_sel, ovf_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cap_reload_timer u_cap_reload_timer (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .irq(irq), .rx_clk_sel(rx_clk_sel),
        .tx_clk_sel(tx_clk_sel), .ovf_pulse(ovf_pulse));

    always_ff @(posedge clk) begin
        if (rst)            pulses <= 0;
        else if (ovf_pulse) pulses <= pulses + 1;
    end

    // vector: [31:28] kind, [27:20] addr, [19:16] requirement, [15:0] value
    localparam int K_WR = 0, K_RD = 1, K_DLY = 2, K_PIN = 3, K_SIG = 4, K_PLS = 5;
    localparam int A_C = 8'hC8, A_CL = 8'hCC, A_CH = 8'hCD, A_RL = 8'hCA, A_RH = 8'hCB;

    function automatic logic [31:0] mk(int k, int a, int r, int v);
        return {4'(k), 8'(a), 4'(r), 16'(v)};
    endfunction

    localparam int NV = 98;
    localparam logic [31:0] VECS [0:NV-1] = '{
        // R2: count the core clock for ten cycles from 0x0010
        mk(K_WR, A_CL, 0, 'h10), mk(K_WR, A_CH, 0, 'h00), mk(K_WR, A_C, 0, 'h04),
        mk(K_DLY, 0, 0, 9), mk(K_WR, A_C, 0, 'h00),
        mk(K_RD, A_CL, 2, 'h1A), mk(K_RD, A_CH, 2, 'h00),
        // R4 / R10: reload on overflow from 0xFFFD, five steps
        mk(K_WR, A_RL, 0, 'h34), mk(K_WR, A_RH, 0, 'h12), mk(K_WR, A_CL, 0, 'hFD),
        mk(K_WR, A_CH, 0, 'hFF), mk(K_WR, A_C, 0, 'h04), mk(K_DLY, 0, 0, 4),
        mk(K_WR, A_C, 0, 'hC0),
        mk(K_RD, A_CL, 4, 'h36), mk(K_RD, A_CH, 4, 'h12), mk(K_RD, A_C, 4, 'h80),
        mk(K_SIG, 0, 10, 'b100), mk(K_WR, A_C, 0, 'h00), mk(K_RD, A_C, 10, 'h00),
        mk(K_SIG, 0, 10, 'b000),
        // R5: capture on trigger, count undisturbed
        mk(K_WR, A_CL, 0, 'h00), mk(K_WR, A_CH, 0, 'h01), mk(K_WR, A_C, 0, 'h0D),
        mk(K_PIN, 0, 0, 'h1), mk(K_DLY, 0, 0, 5), mk(K_WR, A_C, 0, 'hC9),
        mk(K_RD, A_C, 5, 'h49), mk(K_RD, A_CL, 5, 'h07), mk(K_RD, A_CH, 5, 'h01),
        mk(K_RD, A_RL, 5, 'h02), mk(K_RD, A_RH, 5, 'h01), mk(K_PIN, 0, 0, 'h3),
        // R7: trigger without enable is ignored
        mk(K_WR, A_C, 0, 'h05), mk(K_PIN, 0, 0, 'h1), mk(K_DLY, 0, 0, 4),
        mk(K_PIN, 0, 0, 'h3), mk(K_WR, A_C, 0, 'hC1),
        mk(K_RD, A_C, 7, 'h01), mk(K_RD, A_RL, 7, 'h02), mk(K_RD, A_RH, 7, 'h01),
        // R6: reload on trigger
        mk(K_WR, A_CL, 0, 'h00), mk(K_WR, A_CH, 0, 'h50), mk(K_WR, A_C, 0, 'h0C),
        mk(K_PIN, 0, 0, 'h1), mk(K_DLY, 0, 0, 5), mk(K_WR, A_C, 0, 'hC8),
        mk(K_RD, A_C, 6, 'h48), mk(K_RD, A_CL, 6, 'h06), mk(K_RD, A_CH, 6, 'h01),
        mk(K_PIN, 0, 0, 'h3), mk(K_WR, A_C, 0, 'h00),
        // R8 / R9: baud mode with capture bit set and a trigger edge
        mk(K_WR, A_RL, 0, 'h00), mk(K_WR, A_RH, 0, 'hFF), mk(K_WR, A_CL, 0, 'hFE),
        mk(K_WR, A_CH, 0, 'hFF), mk(K_WR, A_C, 0, 'h2D), mk(K_PIN, 0, 0, 'h1),
        mk(K_DLY, 0, 0, 5), mk(K_WR, A_C, 0, 'h29),
        mk(K_RD, A_C, 8, 'h29), mk(K_RD, A_CL, 8, 'h05), mk(K_RD, A_CH, 8, 'hFF),
        mk(K_RD, A_RL, 8, 'h00), mk(K_RD, A_RH, 8, 'hFF), mk(K_SIG, 0, 9, 'b001),
        mk(K_PIN, 0, 0, 'h3), mk(K_PLS, 0, 9, 2), mk(K_WR, A_C, 0, 'h10),
        mk(K_SIG, 0, 9, 'b010), mk(K_WR, A_C, 0, 'h00),
        // R3: three falling edges on the count pin
        mk(K_WR, A_CL, 0, 'h00), mk(K_WR, A_CH, 0, 'h00), mk(K_WR, A_C, 0, 'h06),
        mk(K_PIN, 0, 0, 'h2), mk(K_PIN, 0, 0, 'h3), mk(K_PIN, 0, 0, 'h2),
        mk(K_PIN, 0, 0, 'h3), mk(K_PIN, 0, 0, 'h2), mk(K_DLY, 0, 0, 4),
        mk(K_WR, A_C, 0, 'h02), mk(K_RD, A_CL, 3, 'h03), mk(K_RD, A_CH, 3, 'h00),
        mk(K_PIN, 0, 0, 'h3),
        // R11: capture lands on the overflow cycle
        mk(K_WR, A_CL, 0, 'hFD), mk(K_WR, A_CH, 0, 'hFF), mk(K_WR, A_C, 0, 'h0D),
        mk(K_PIN, 0, 0, 'h1), mk(K_DLY, 0, 0, 5), mk(K_WR, A_C, 0, 'hC9),
        mk(K_RD, A_C, 11, 'hC9), mk(K_RD, A_CL, 11, 'h04), mk(K_RD, A_CH, 11, 'h00),
        mk(K_RD, A_RL, 11, 'hFF), mk(K_RD, A_RH, 11, 'hFF), mk(K_SIG, 0, 11, 'b100),
        mk(K_PLS, 0, 11, 3), mk(K_PIN, 0, 0, 'h3)
    };

    task automatic check(int req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] v);
        int k = int'(v[31:28]);
        int r = int'(v[19:16]);
        @(negedge clk);
        sfr_wr = 1'b0;
        case (k)
            K_WR: begin
                sfr_addr = v[27:20]; sfr_wdata = v[7:0]; sfr_wr = 1'b1;
            end
            K_RD: begin
                sfr_addr = v[27:20]; #1;
                check(r, int'(sfr_rdata), int'(v[7:0]));
            end
            K_DLY: repeat (int'(v[15:0]) - 1) @(negedge clk);
            K_PIN: begin
                cnt_pin = v[0]; trig_pin = v[1];
            end
            K_SIG: check(r, int'({irq, tx_clk_sel, rx_clk_sel}), int'(v[2:0]));
            K_PLS: check(r, pulses, int'(v[15:0]));
            default: ;
        endcase
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        sfr_addr = 8'hC8; #1; check(1, int'(sfr_rdata), 0);
        sfr_addr = 8'hCC; #1; check(1, int'(sfr_rdata), 0);
        check(1, int'({irq, tx_clk_sel, rx_clk_sel, ovf_pulse}), 0);

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R1: reset in the middle of a run clears everything
        apply(mk(K_WR, 8'hC8, 0, 'h34));
        apply(mk(K_DLY, 0, 0, 3));
        @(negedge clk); sfr_wr = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        sfr_addr = 8'hC8; #1; check(1, int'(sfr_rdata), 0);
        sfr_addr = 8'hCC; #1; check(1, int'(sfr_rdata), 0);
        sfr_addr = 8'hCA; #1; check(1, int'(sfr_rdata), 0);
        sfr_addr = 8'hCB; #1; check(1, int'(sfr_rdata), 0);
        check(1, int'({irq, tx_clk_sel, rx_clk_sel, ovf_pulse}), 0);
        // R2: stopped after reset, the count holds
        repeat (5) @(negedge clk);
        sfr_addr = 8'hCC; #1; check(2, int'(sfr_rdata), 0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule